// File: doc/BRIEF.md
# Channel Group Power and Initialization Controller

This block keeps one small control register for each channel group of a multi-group voice processing chip. Each register decides whether the group's two processing units (A and B) and their tone detectors are running, which companding law and which PCM code format both units use, and whether each unit's tone interrupt reaches the output. A host reads and writes the control registers and a per-group 64-byte block of per-channel registers through a simple synchronous port. The read data appears on the cycle after the read strobe.

While a group is switched off, its receive and send PCM samples are not processed. They go through a delay line that advances on each frame-sync pulse and delivers every sample exactly two frames late. When the power bit of a group goes from 0 to 1, a per-group sequencer wipes the group's 64 per-channel registers to their default of zero. It then sweeps every address of the group's coefficient memory with a clear strobe and holds a busy flag until two frame pulses have passed and the sweep is complete.

The sequencer of each group has these states. GS_OFF is bypass. GS_INIT_F1 waits for the first frame pulse. GS_INIT_F2 waits for the second. GS_DRAIN is entered when the second pulse arrives before the sweep ends. GS_RUN is normal operation. The transitions are:
- OFF to INIT_F1 when the power bit is set. The register wipe happens on this edge.
- INIT_F1 to INIT_F2 on a frame pulse.
- INIT_F2 to RUN on a frame pulse once the sweep is done, or to DRAIN on a frame pulse while the sweep is still running.
- DRAIN to RUN when the sweep is done.
- Any state to OFF when the power bit is clear.

Top module: `grp_pwr_ctl`

## Requirements
- R1: After reset every control register reads 0x00, every per-channel register reads 0x00, no busy flag, coefficient clear strobe or interrupt is active, and all PCM outputs are 0.
- R2: The control register of group g (0-based) is at host address 0x401+g. Bit 0 is the power bit, bit 1 is the law select, bit 2 is the format select, bit 3 masks unit A's tone interrupt, and bit 4 masks unit B's. Bits 7:5 always read 0. Read data is valid the cycle after the read strobe. Addresses that map to nothing read 0.
- R3: law_o[g] follows bit 1 (1 = A-law, 0 = mu-law) and fmt_o[g] follows bit 2 (1 = ITU-T coding, 0 = sign-magnitude) of group g's register. Each select is a single signal shared by both units of the group.
- R4: irq_a_o[g] is tone_a_i[g] when bit 3 is 0 and the group is in GS_RUN, and 0 otherwise. irq_b_o[g] is the same for tone_b_i[g] and bit 4.
- R5: Outside GS_RUN, rout_o/sout_o of a group show the rin_i/sin_i sample captured at the frame pulse two pulses earlier, so a sample is delayed exactly two frames.
- R6: In GS_RUN, rout_o/sout_o of a group carry ec_rout_i/ec_sout_i of that group.
- R7: On the clock edge after the power bit of group g becomes 1, the per-channel registers at addresses g*64 to g*64+63 are cleared to 0x00 and busy_o[g] rises.
- R8: From the cycle busy_o[g] rises, coef_clr_en_o[g] is high for COEF_DEPTH consecutive cycles while coef_clr_addr_o of group g steps through 0 to COEF_DEPTH-1.
- R9: busy_o[g] falls on the edge of the second frame pulse counted after init start, or once the sweep completes if that is later. A frame pulse on the same edge as the init start is not counted.
- R10: A host write to a group's per-channel space is ignored while that group's busy flag is high, and also on the edge that performs the wipe.
- R11: A 1-to-0 change of the power bit ends any initialization on the next edge: busy and clear strobe drop, and the PCM outputs return to the bypass delay line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| fsync_i | input | 1 | one-cycle frame pulse |
| host_we_i | input | 1 | host write strobe |
| host_re_i | input | 1 | host read strobe |
| host_addr_i | input | ADDR_W (12) | host byte address |
| host_wdata_i | input | 8 | host write data |
| host_rdata_o | output | 8 | host read data, one cycle after the read strobe |
| tone_a_i | input | NUM_GRP (15) | tone detector A events per group |
| tone_b_i | input | NUM_GRP | tone detector B events per group |
| irq_a_o | output | NUM_GRP | gated tone interrupt A per group |
| irq_b_o | output | NUM_GRP | gated tone interrupt B per group |
| law_o | output | NUM_GRP | law select per group, shared by both units |
| fmt_o | output | NUM_GRP | code format select per group, shared by both units |
| busy_o | output | NUM_GRP | initialization in progress per group |
| coef_clr_en_o | output | NUM_GRP | coefficient clear write strobe per group |
| coef_clr_addr_o | output | NUM_GRP*log2(COEF_DEPTH) (75) | coefficient clear address per group |
| rin_i | input | NUM_GRP*PCM_W (120) | receive-side samples in |
| sin_i | input | NUM_GRP*PCM_W | send-side samples in |
| ec_rout_i | input | NUM_GRP*PCM_W | processed receive samples from the units |
| ec_sout_i | input | NUM_GRP*PCM_W | processed send samples from the units |
| rout_o | output | NUM_GRP*PCM_W | receive-side samples out |
| sout_o | output | NUM_GRP*PCM_W | send-side samples out |

## Verification
Two events can meet on one clock edge: the wipe of a group's per-channel registers and a host write into that same space. The wipe happens on the edge after the power bit is written, and on that edge the busy flag is not yet high. The bench provokes this by writing a nonzero value into a per-channel register of the group on the write cycle that immediately follows the power-up write. It judges the outcome by reading the register back: it must read 0, because the wipe takes priority. A second such pair is a frame pulse that arrives on the same edge as the init start. The bench judges that one by checking that busy_o is still high after two further pulses while the sweep is still running.

// File: rtl/grp_pkg.sv
package grp_pkg;

    typedef enum logic [2:0] {
        GS_OFF,
        GS_INIT_F1,
        GS_INIT_F2,
        GS_DRAIN,
        GS_RUN
    } grp_state_t;

    localparam int CTL_PWR  = 0;
    localparam int CTL_LAW  = 1;
    localparam int CTL_FMT  = 2;
    localparam int CTL_MSKA = 3;
    localparam int CTL_MSKB = 4;
    localparam int CTL_BITS = 5;
    localparam int HOST_DW  = 8;

endpackage

// File: rtl/grp_seq.sv
module grp_seq
    import grp_pkg::*;
#(
    parameter int COEF_DEPTH = 32,
    localparam int CAW   = $clog2(COEF_DEPTH),
    localparam int CNT_W = $clog2(COEF_DEPTH + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           pwr_i,
    input  logic           fsync_i,
    output logic           busy_o,
    output logic           run_o,
    output logic           wipe_o,
    output logic           coef_en_o,
    output logic [CAW-1:0] coef_addr_o
);

    grp_state_t state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic sweep_done;

    assign sweep_done = (cnt_q == CNT_W'(COEF_DEPTH));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GS_OFF:     if (pwr_i) state_d = GS_INIT_F1;
            GS_INIT_F1: if (!pwr_i) state_d = GS_OFF;
                        else if (fsync_i) state_d = GS_INIT_F2;
            GS_INIT_F2: if (!pwr_i) state_d = GS_OFF;
                        else if (fsync_i) state_d = sweep_done ? GS_RUN : GS_DRAIN;
            GS_DRAIN:   if (!pwr_i) state_d = GS_OFF;
                        else if (sweep_done) state_d = GS_RUN;
            GS_RUN:     if (!pwr_i) state_d = GS_OFF;
            default:    state_d = GS_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= GS_OFF;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          cnt_q <= '0;
        else if (state_q == GS_OFF && pwr_i) cnt_q <= '0;
        else if (coef_en_o)                  cnt_q <= cnt_q + 1'b1;
    end

    always_comb begin
        busy_o      = (state_q == GS_INIT_F1) || (state_q == GS_INIT_F2) ||
                      (state_q == GS_DRAIN);
        run_o       = (state_q == GS_RUN);
        wipe_o      = (state_q == GS_OFF) && pwr_i;
        coef_en_o   = busy_o && !sweep_done;
        coef_addr_o = cnt_q[CAW-1:0];
    end

endmodule

// File: rtl/grp_bypass.sv
module grp_bypass #(
    parameter int PCM_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fsync_i,
    input  logic             run_i,
    input  logic [PCM_W-1:0] raw_i,
    input  logic [PCM_W-1:0] proc_i,
    output logic [PCM_W-1:0] out_o
);

    logic [PCM_W-1:0] stage1_q, stage2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else if (fsync_i) begin
            stage1_q <= raw_i;
            stage2_q <= stage1_q;
        end
    end

    assign out_o = run_i ? proc_i : stage2_q;

endmodule

// File: rtl/grp_regfile.sv
module grp_regfile
    import grp_pkg::*;
#(
    parameter int NUM_GRP = 15,
    parameter int SPAN    = 64,
    parameter int ADDR_W  = 12,
    localparam int TOTAL    = NUM_GRP * SPAN,
    localparam int SPAN_LOG = $clog2(SPAN),
    localparam int GRP_W    = $clog2(NUM_GRP),
    localparam int IDX_W    = $clog2(TOTAL)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we_i,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic [HOST_DW-1:0] wdata_i,
    input  logic [NUM_GRP-1:0] busy_i,
    input  logic [NUM_GRP-1:0] wipe_i,
    output logic               hit_o,
    output logic [HOST_DW-1:0] rdata_o
);

    logic [HOST_DW-1:0] mem_q [TOTAL];
    logic [IDX_W-1:0]   idx;
    logic [GRP_W-1:0]   grp;
    logic               wr_ok;

    assign hit_o = (addr_i < ADDR_W'(TOTAL));
    assign idx   = addr_i[IDX_W-1:0];
    assign grp   = addr_i[SPAN_LOG +: GRP_W];
    assign wr_ok = we_i && hit_o && !busy_i[grp] && !wipe_i[grp];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < TOTAL; k++) mem_q[k] <= '0;
        end else begin
            if (wr_ok) mem_q[idx] <= wdata_i;
            for (int g = 0; g < NUM_GRP; g++) begin
                if (wipe_i[g]) begin
                    for (int i = 0; i < SPAN; i++) mem_q[g*SPAN + i] <= '0;
                end
            end
        end
    end

    assign rdata_o = hit_o ? mem_q[idx] : '0;

endmodule

// File: rtl/grp_pwr_ctl.sv
module grp_pwr_ctl
    import grp_pkg::*;
#(
    parameter int NUM_GRP    = 15,
    parameter int SPAN       = 64,
    parameter int COEF_DEPTH = 32,
    parameter int PCM_W      = 8,
    parameter int ADDR_W     = 12,
    parameter int CTRL_BASE  = 'h401,
    localparam int CAW   = $clog2(COEF_DEPTH),
    localparam int GRP_W = $clog2(NUM_GRP)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     fsync_i,
    input  logic                     host_we_i,
    input  logic                     host_re_i,
    input  logic [ADDR_W-1:0]        host_addr_i,
    input  logic [HOST_DW-1:0]       host_wdata_i,
    output logic [HOST_DW-1:0]       host_rdata_o,
    input  logic [NUM_GRP-1:0]       tone_a_i,
    input  logic [NUM_GRP-1:0]       tone_b_i,
    output logic [NUM_GRP-1:0]       irq_a_o,
    output logic [NUM_GRP-1:0]       irq_b_o,
    output logic [NUM_GRP-1:0]       law_o,
    output logic [NUM_GRP-1:0]       fmt_o,
    output logic [NUM_GRP-1:0]       busy_o,
    output logic [NUM_GRP-1:0]       coef_clr_en_o,
    output logic [NUM_GRP*CAW-1:0]   coef_clr_addr_o,
    input  logic [NUM_GRP*PCM_W-1:0] rin_i,
    input  logic [NUM_GRP*PCM_W-1:0] sin_i,
    input  logic [NUM_GRP*PCM_W-1:0] ec_rout_i,
    input  logic [NUM_GRP*PCM_W-1:0] ec_sout_i,
    output logic [NUM_GRP*PCM_W-1:0] rout_o,
    output logic [NUM_GRP*PCM_W-1:0] sout_o
);

    logic [CTL_BITS-1:0] ctrl_q [NUM_GRP];
    logic [NUM_GRP-1:0]  pwr_on, run, wipe;
    logic                ctrl_hit, chan_hit;
    logic [GRP_W-1:0]    cidx;
    logic [HOST_DW-1:0]  chan_rdata;

    assign ctrl_hit = (host_addr_i >= ADDR_W'(CTRL_BASE)) &&
                      (host_addr_i <  ADDR_W'(CTRL_BASE + NUM_GRP));
    assign cidx     = GRP_W'(host_addr_i - ADDR_W'(CTRL_BASE));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int g = 0; g < NUM_GRP; g++) ctrl_q[g] <= '0;
        end else if (host_we_i && ctrl_hit) begin
            ctrl_q[cidx] <= host_wdata_i[CTL_BITS-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            host_rdata_o <= '0;
        end else if (host_re_i) begin
            if (ctrl_hit)
                host_rdata_o <= {{(HOST_DW-CTL_BITS){1'b0}}, ctrl_q[cidx]};
            else if (chan_hit)
                host_rdata_o <= chan_rdata;
            else
                host_rdata_o <= '0;
        end
    end

    grp_regfile #(
        .NUM_GRP (NUM_GRP),
        .SPAN    (SPAN),
        .ADDR_W  (ADDR_W)
    ) i_regfile (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (host_we_i),
        .addr_i  (host_addr_i),
        .wdata_i (host_wdata_i),
        .busy_i  (busy_o),
        .wipe_i  (wipe),
        .hit_o   (chan_hit),
        .rdata_o (chan_rdata)
    );

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        assign pwr_on[g]  = ctrl_q[g][CTL_PWR];
        assign law_o[g]   = ctrl_q[g][CTL_LAW];
        assign fmt_o[g]   = ctrl_q[g][CTL_FMT];
        assign irq_a_o[g] = tone_a_i[g] && !ctrl_q[g][CTL_MSKA] && run[g];
        assign irq_b_o[g] = tone_b_i[g] && !ctrl_q[g][CTL_MSKB] && run[g];

        grp_seq #(.COEF_DEPTH(COEF_DEPTH)) i_seq (
            .clk         (clk),
            .rst_n       (rst_n),
            .pwr_i       (pwr_on[g]),
            .fsync_i     (fsync_i),
            .busy_o      (busy_o[g]),
            .run_o       (run[g]),
            .wipe_o      (wipe[g]),
            .coef_en_o   (coef_clr_en_o[g]),
            .coef_addr_o (coef_clr_addr_o[g*CAW +: CAW])
        );

        grp_bypass #(.PCM_W(PCM_W)) i_rx (
            .clk     (clk),
            .rst_n   (rst_n),
            .fsync_i (fsync_i),
            .run_i   (run[g]),
            .raw_i   (rin_i[g*PCM_W +: PCM_W]),
            .proc_i  (ec_rout_i[g*PCM_W +: PCM_W]),
            .out_o   (rout_o[g*PCM_W +: PCM_W])
        );

        grp_bypass #(.PCM_W(PCM_W)) i_tx (
            .clk     (clk),
            .rst_n   (rst_n),
            .fsync_i (fsync_i),
            .run_i   (run[g]),
            .raw_i   (sin_i[g*PCM_W +: PCM_W]),
            .proc_i  (ec_sout_i[g*PCM_W +: PCM_W]),
            .out_o   (sout_o[g*PCM_W +: PCM_W])
        );
    end

endmodule

// File: rtl/grp_pwr_chk.sv
module grp_pwr_chk
    import grp_pkg::*;
#(
    parameter int NUM_GRP    = 15,
    parameter int COEF_DEPTH = 32,
    parameter int ADDR_W     = 12,
    parameter int CTRL_BASE  = 'h401,
    localparam int CAW = $clog2(COEF_DEPTH)
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   host_we_i,
    input logic                   host_re_i,
    input logic [ADDR_W-1:0]      host_addr_i,
    input logic [HOST_DW-1:0]     host_rdata_o,
    input logic [NUM_GRP-1:0]     tone_a_i,
    input logic [NUM_GRP-1:0]     tone_b_i,
    input logic [NUM_GRP-1:0]     irq_a_o,
    input logic [NUM_GRP-1:0]     irq_b_o,
    input logic [NUM_GRP-1:0]     law_o,
    input logic [NUM_GRP-1:0]     fmt_o,
    input logic [NUM_GRP-1:0]     busy_o,
    input logic [NUM_GRP-1:0]     coef_clr_en_o,
    input logic [NUM_GRP*CAW-1:0] coef_clr_addr_o,
    input logic [NUM_GRP-1:0]     pwr_on
);

    // R2
    rd_pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(host_re_i) && $past(host_addr_i) >= ADDR_W'(CTRL_BASE) &&
         $past(host_addr_i) < ADDR_W'(CTRL_BASE + NUM_GRP))
        |-> host_rdata_o[HOST_DW-1:CTL_BITS] == '0);

    // R3
    sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(host_we_i) |-> ($stable(law_o) && $stable(fmt_o)));

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_chk
        // R4
        irq_a_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
            irq_a_o[g] |-> (tone_a_i[g] && !busy_o[g] && pwr_on[g]));
        // R4
        irq_b_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
            irq_b_o[g] |-> (tone_b_i[g] && !busy_o[g] && pwr_on[g]));
        // R8
        clr_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
            coef_clr_en_o[g] |-> busy_o[g]);
        // R8
        sweep_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(busy_o[g]) |->
            (coef_clr_en_o[g] && coef_clr_addr_o[g*CAW +: CAW] == '0));
        // R9
        sweep_before_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($fell(busy_o[g]) && $past(pwr_on[g])) |-> !$past(coef_clr_en_o[g]));
        // R11
        off_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!pwr_on[g] && !$past(pwr_on[g])) |-> (!busy_o[g] && !coef_clr_en_o[g]));
    end

endmodule

bind grp_pwr_ctl grp_pwr_chk #(
    .NUM_GRP    (NUM_GRP),
    .COEF_DEPTH (COEF_DEPTH),
    .ADDR_W     (ADDR_W),
    .CTRL_BASE  (CTRL_BASE)
) i_grp_pwr_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .host_we_i       (host_we_i),
    .host_re_i       (host_re_i),
    .host_addr_i     (host_addr_i),
    .host_rdata_o    (host_rdata_o),
    .tone_a_i        (tone_a_i),
    .tone_b_i        (tone_b_i),
    .irq_a_o         (irq_a_o),
    .irq_b_o         (irq_b_o),
    .law_o           (law_o),
    .fmt_o           (fmt_o),
    .busy_o          (busy_o),
    .coef_clr_en_o   (coef_clr_en_o),
    .coef_clr_addr_o (coef_clr_addr_o),
    .pwr_on          (pwr_on)
);

// File: tb/test_grp_pwr_ctl.sv
module test_grp_pwr_ctl;

    localparam int G   = 15;
    localparam int PW  = 8;
    localparam int CD  = 32;
    localparam int CAW = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fsync = 1'b0;
    logic we = 1'b0, re = 1'b0;
    logic [11:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic [G-1:0] tone_a = '0, tone_b = '0;
    logic [G-1:0] irq_a, irq_b, law, fmt, busy, clr_en;
    logic [G*CAW-1:0] clr_addr;
    logic [G*PW-1:0] rin = '0, sin = '0, ec_r = '0, ec_s = '0, rout, sout;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    grp_pwr_ctl i_grp_pwr_ctl (
        .clk(clk), .rst_n(rst_n), .fsync_i(fsync),
        .host_we_i(we), .host_re_i(re), .host_addr_i(addr),
        .host_wdata_i(wdata), .host_rdata_o(rdata),
        .tone_a_i(tone_a), .tone_b_i(tone_b), .irq_a_o(irq_a), .irq_b_o(irq_b),
        .law_o(law), .fmt_o(fmt), .busy_o(busy),
        .coef_clr_en_o(clr_en), .coef_clr_addr_o(clr_addr),
        .rin_i(rin), .sin_i(sin), .ec_rout_i(ec_r), .ec_sout_i(ec_s),
        .rout_o(rout), .sout_o(sout)
    );

    function automatic logic exp_irq(logic tone, logic mask, logic running);
        return tone && !mask && running;
    endfunction

    function automatic logic [7:0] exp_ctrl_read(logic [7:0] d);
        return {3'b000, d[4:0]};
    endfunction

    task automatic check(logic ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic wr(logic [11:0] a, logic [7:0] d);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(logic [11:0] a, output logic [7:0] v);
        addr = a; re = 1'b1;
        @(negedge clk);
        re = 1'b0;
        v = rdata;
    endtask

    task automatic pulse();
        fsync = 1'b1;
        @(negedge clk);
        fsync = 1'b0;
    endtask

    task automatic report();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
        report();
    end

    initial begin
        logic [7:0] v;
        void'($urandom(32'd4242));
        repeat (3) step();
        rst_n = 1'b1;
        step();

        // R1 reset state
        rd(12'h401, v);  check(v == 8'h00, "R1 ctrl", v, 0);
        rd(12'h0C5, v);  check(v == 8'h00, "R1 chan", v, 0);
        check(busy == '0 && clr_en == '0 && irq_a == '0, "R1 flags", int'(busy), 0);
        check(rout == '0 && sout == '0, "R1 pcm", int'(rout[7:0]), 0);
        rd(12'h7FF, v);  check(v == 8'h00, "R2 unmapped", v, 0);

        // preload per-channel registers
        wr(12'h0C5, 8'hA5); rd(12'h0C5, v); check(v == 8'hA5, "R10 preload", v, 8'hA5);
        wr(12'h142, 8'h77);

        // R5 bypass delay on group 0
        rin[7:0] = 8'h11; sin[7:0] = 8'h81; pulse();
        check(rout[7:0] == 8'h00, "R5 one frame", rout[7:0], 0);
        rin[7:0] = 8'h22; sin[7:0] = 8'h82; pulse();
        check(rout[7:0] == 8'h11, "R5 rx two frames", rout[7:0], 8'h11);
        check(sout[7:0] == 8'h81, "R5 tx two frames", sout[7:0], 8'h81);
        rin[7:0] = 8'h33; pulse();
        check(rout[7:0] == 8'h22, "R5 rx next", rout[7:0], 8'h22);

        // R4 off group never interrupts
        tone_a[0] = 1'b1; tone_b[0] = 1'b1; step();
        check(irq_a[0] == 1'b0 && irq_b[0] == 1'b0, "R4 off group", irq_a[0], 0);
        tone_a[0] = 1'b0; tone_b[0] = 1'b0;

        // R7 R8 power up group 3
        wr(12'h404, 8'h01);
        check(busy[3] == 1'b0, "R7 busy not yet", busy[3], 0);
        step();
        check(busy[3] == 1'b1, "R7 busy rises", busy[3], 1);
        for (int k = 0; k < CD; k++) begin
            check(clr_en[3] && clr_addr[3*CAW +: CAW] == k, "R8 sweep",
                  clr_addr[3*CAW +: CAW], k);
            step();
        end
        check(clr_en[3] == 1'b0, "R8 sweep end", clr_en[3], 0);
        rd(12'h0C5, v);  check(v == 8'h00, "R7 wiped", v, 0);
        wr(12'h0C5, 8'h5A); rd(12'h0C5, v);
        check(v == 8'h00, "R10 busy write ignored", v, 0);
        pulse(); check(busy[3] == 1'b1, "R9 after one pulse", busy[3], 1);
        pulse(); check(busy[3] == 1'b0, "R9 after two pulses", busy[3], 0);
        wr(12'h0C5, 8'h5A); rd(12'h0C5, v);
        check(v == 8'h5A, "R10 write after init", v, 8'h5A);
        ec_r[3*PW +: PW] = 8'hC3; ec_s[3*PW +: PW] = 8'h3C; step();
        check(rout[3*PW +: PW] == 8'hC3, "R6 rx processed", rout[3*PW +: PW], 8'hC3);
        check(sout[3*PW +: PW] == 8'h3C, "R6 tx processed", sout[3*PW +: PW], 8'h3C);

        // R2 R3 R4 random control on running group 3
        for (int i = 0; i < 40; i++) begin
            logic [7:0] d;
            d = 8'($urandom);
            d[0] = 1'b1;
            tone_a[3] = 1'($urandom); tone_b[3] = 1'($urandom);
            wr(12'h404, d);
            check(law[3] == d[1], "R3 law", law[3], d[1]);
            check(fmt[3] == d[2], "R3 fmt", fmt[3], d[2]);
            check(irq_a[3] == exp_irq(tone_a[3], d[3], 1'b1), "R4 irq a", irq_a[3], d[3]);
            check(irq_b[3] == exp_irq(tone_b[3], d[4], 1'b1), "R4 irq b", irq_b[3], d[4]);
            rd(12'h404, v);
            check(v == exp_ctrl_read(d), "R2 readback", v, exp_ctrl_read(d));
        end
        for (int i = 0; i < 20; i++) begin
            logic [7:0] d;
            int gsel;
            gsel = 10 + int'($urandom % 5);
            d = 8'($urandom);
            d[0] = 1'b0;
            wr(12'(12'h401 + gsel), d);
            rd(12'(12'h401 + gsel), v);
            check(v == exp_ctrl_read(d), "R2 random group", v, exp_ctrl_read(d));
            check(law[gsel] == d[1] && fmt[gsel] == d[2], "R3 random group", law[gsel], d[1]);
        end
        tone_a[3] = 1'b0; tone_b[3] = 1'b0;

        // R10 R7 wipe meets a host write on the same edge (group 5)
        wr(12'h406, 8'h01);
        wr(12'h142, 8'h99);
        rd(12'h142, v);  check(v == 8'h00, "R10 wipe beats write", v, 0);

        // R9 frame pulse on the start edge, then drain (group 7)
        wr(12'h408, 8'h01);
        pulse(); pulse(); pulse();
        check(busy[7] == 1'b1, "R9 start-edge pulse ignored", busy[7], 1);
        repeat (40) step();
        check(busy[7] == 1'b0, "R9 drain done", busy[7], 0);

        // R11 power down in the middle of init (group 9)
        wr(12'h40A, 8'h01);
        repeat (3) step();
        check(clr_en[9] == 1'b1, "R11 sweeping", clr_en[9], 1);
        wr(12'h40A, 8'h00);
        step();
        check(busy[9] == 1'b0 && clr_en[9] == 1'b0, "R11 aborted", busy[9], 0);

        // R11 running group back to bypass
        wr(12'h404, 8'h00);
        step();
        check(rout[3*PW +: PW] == 8'h00, "R11 bypass restored", rout[3*PW +: PW], 0);

        report();
    end

endmodule